// File: doc/BRIEF.md
# External bus wait-state generator

This block sits between a processor core and a slow peripheral bus that exposes eight register-mapped slots, numbered 0 to 7. The core presents an access (slot number, direction, write data) and holds its request until the block answers with a one-cycle ready pulse. For each access the block decides from a 16-bit control register whether to stall the core for one extra cycle. It can also keep stalling for as long as an external, active-high wait input is held. It drives a strobe, direction, slot number and write data toward the peripheral for the whole access. It captures read data in the completion cycle.

The control register is reached over the same core interface by raising the configuration select instead of addressing a slot. It holds a 2-bit wait field for each of slots 0 to 6, an enable for the external wait input and an enable for a pair of user output pins. Slot 7 is internal and is never stalled.

Top module: `extbus_waitgen`

## Requirements
- R1: After reset the control register reads 0, `user_out_en` is 0, `core_rdata` is 0, and every slot completes in one cycle.
- R2: A write with `core_cfg` high loads the control register from `core_wdata` and completes in the cycle it is presented. A later read with `core_cfg` high returns that value on `core_rdata`.
- R3: A slot whose 2-bit field holds 00 or 01 completes reads and writes in one cycle: `core_ready` is high in the first cycle of the request.
- R4: A slot whose field holds 10 or 11 completes reads and writes in two cycles: `core_ready` is low in the first cycle and high in the second.
- R5: The field for slot n occupies control bits [2n+1:2n], for n = 0 to 6.
- R6: Slot 7 always completes in one cycle, whatever the control register holds and whatever the wait input does.
- R7: While control bit 14 is 0, the wait input has no effect on any access.
- R8: While control bit 14 is 1, each cycle after the programmed wait state in which `ext_wait` is high adds one stall cycle. The access completes in the first such cycle in which `ext_wait` is low. Holding it for k cycles gives 2+k cycles.
- R9: `core_ready` is high only while `core_req` is high, and for exactly one cycle per access. `per_strobe` is high in every cycle of a slot access and low for control register accesses.
- R10: Read data (peripheral or control register) is captured at the clock edge ending the completion cycle. It appears on `core_rdata` from the next cycle until the next read completes.
- R11: `user_out_en` equals control bit 15.
- R12: The wait input never stretches an access to a slot whose field selects no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Access request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_cfg | input | 1 | Access targets the control register instead of a slot |
| core_slot | input | SW (3) | Slot number |
| core_wdata | input | 16 | Write data |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | 16 | Captured read data |
| per_strobe | output | 1 | Peripheral access in progress |
| per_we | output | 1 | Peripheral write direction |
| per_slot | output | SW (3) | Peripheral slot number |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| ext_wait | input | 1 | External wait request, active high |
| user_out_en | output | 1 | Enable for the user output pins |

## Verification
`core_ready` and `per_strobe` depend on the present request, so the bench sets inputs at the falling edge and compares them 2 ns later, in the same cycle. `core_rdata` and `user_out_en` change at the rising edge that ends a completing access, so they are compared from the following cycle on. The bench model advances its stall phase, control register and captured data only at that rising edge. It also counts the cycles each access takes, from the first request cycle to the ready cycle inclusive, and compares the count with 1, 2 or 2+k as the requirements give.

// File: rtl/extbus_waitgen.sv
module extbus_waitgen #(
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_req,
  input  logic                 core_we,
  input  logic                 core_cfg,
  input  logic [SW-1:0]        core_slot,
  input  logic [2*(1<<SW)-1:0] core_wdata,
  output logic                 core_ready,
  output logic [2*(1<<SW)-1:0] core_rdata,
  output logic                 per_strobe,
  output logic                 per_we,
  output logic [SW-1:0]        per_slot,
  output logic [2*(1<<SW)-1:0] per_wdata,
  input  logic [2*(1<<SW)-1:0] per_rdata,
  input  logic                 ext_wait,
  output logic                 user_out_en
);
  localparam int NSLOT  = 1 << SW;
  localparam int DW     = 2 * NSLOT;
  localparam int WENBIT = DW - 2;
  localparam int UOBIT  = DW - 1;
  localparam logic [SW-1:0] INTSLOT = SW'(NSLOT - 1);

  logic [DW-1:0] ctrl;
  logic          held;
  logic          need_ws, stretch;

  assign need_ws     = !core_cfg && core_slot != INTSLOT && ctrl[{core_slot, 1'b1}];
  assign stretch     = ctrl[WENBIT] && ext_wait;
  assign core_ready  = core_req && (!need_ws || (held && !stretch));
  assign per_strobe  = core_req && !core_cfg;
  assign per_we      = core_we;
  assign per_slot    = core_slot;
  assign per_wdata   = core_wdata;
  assign user_out_en = ctrl[UOBIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      held       <= 1'b0;
      core_rdata <= '0;
    end else begin
      held <= core_req && !core_ready;
      if (core_req && core_ready) begin
        if (core_we && core_cfg) ctrl <= core_wdata;
        if (!core_we) core_rdata <= core_cfg ? ctrl : per_rdata;
      end
    end
  end

  // R6
  int_slot_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_cfg && core_slot == INTSLOT) |-> core_ready);
  // R9
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> core_req);
  // R7
  single_ws_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && core_req && !ctrl[WENBIT]) |-> core_ready);
  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_ready && core_cfg && core_we) |=> ctrl == $past(core_wdata));
  // R10
  rdata_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_ready && !core_cfg && !core_we) |=> core_rdata == $past(per_rdata));
  // R9
  strobe_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_cfg |-> !per_strobe);
endmodule

// File: tb/extbus_waitgen_bench.sv
module extbus_waitgen_bench;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, cfg = 0, pin = 0;
  logic [2:0] slot = 0;
  logic [15:0] wdata = 0, prdata = 0;
  logic ready, strobe, pwe, uo;
  logic [2:0] pslot;
  logic [15:0] rdata, pwdata;

  int vectors = 0, miscompares = 0;
  logic [15:0] m_ctrl = 0, m_rdata = 0;
  int m_phase = 0;

  always #10 clk = ~clk;

  extbus_waitgen u_extbus_waitgen (
    .clk(clk), .rst_n(rst_n), .core_req(req), .core_we(we), .core_cfg(cfg),
    .core_slot(slot), .core_wdata(wdata), .core_ready(ready), .core_rdata(rdata),
    .per_strobe(strobe), .per_we(pwe), .per_slot(pslot), .per_wdata(pwdata),
    .per_rdata(prdata), .ext_wait(pin), .user_out_en(uo));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(output bit rdy);
    bit need, exp_rdy;
    #2;
    need = !cfg && slot != 3'd7 && m_ctrl[2*slot+1];
    exp_rdy = req && (!need || (m_phase >= 1 && !(m_ctrl[14] && pin)));
    chk(ready === exp_rdy, "R9 core_ready", ready, exp_rdy);
    chk(strobe === (req && !cfg), "R9 per_strobe", strobe, req && !cfg);
    chk(rdata === m_rdata, "R10 core_rdata", rdata, m_rdata);
    chk(uo === m_ctrl[15], "R11 user_out_en", uo, m_ctrl[15]);
    rdy = ready;
    @(posedge clk);
    if (req && exp_rdy) begin
      if (!we) m_rdata = cfg ? m_ctrl : prdata;
      if (we && cfg) m_ctrl = wdata;
      m_phase = 0;
    end else if (req) m_phase++;
    else m_phase = 0;
    @(negedge clk);
  endtask

  task automatic access(input bit c, input int s, input bit w, input logic [15:0] d,
                        input int extra, input int exp_cyc, input string tag);
    int n = 0;
    bit r = 0;
    req = 1; cfg = c; slot = 3'(s); we = w; wdata = d;
    prdata = 16'h5A00 ^ d ^ 16'(s * 16'h0111);
    while (!r && n < 20) begin
      pin = (n <= extra);
      step(r);
      n++;
    end
    req = 0; pin = 0;
    chk(n == exp_cyc, {tag, " access cycles"}, n, exp_cyc);
  endtask

  task automatic idle(input int k);
    bit r;
    for (int i = 0; i < k; i++) step(r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    idle(1);
    // R1: reset state
    chk(uo === 1'b0 && rdata === 16'h0, "R1 reset outputs", {uo, rdata}, 0);
    access(0, 3, 0, 16'h0, -1, 1, "R1");
    access(1, 0, 0, 16'h0, -1, 1, "R1");
    idle(1);
    chk(rdata === 16'h0, "R1 control reads zero", rdata, 0);

    // R2 write/readback, R11 user output enable
    access(1, 0, 1, 16'h8123, -1, 1, "R2");
    access(1, 0, 0, 16'h0, -1, 1, "R2");
    idle(1);
    chk(rdata === 16'h8123, "R2 readback", rdata, 16'h8123);
    chk(uo === 1'b1, "R11 bit15 set", uo, 1);

    // R3 R4 R5 R6: every slot, every field value, reads and writes
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 4; v++) begin
        logic [15:0] val = 16'h0;
        int exp_cyc;
        if (s < 7) val[2*s +: 2] = 2'(v);
        else val[13:0] = 14'h3FFF;
        access(1, 0, 1, val, -1, 1, "R2");
        exp_cyc = (s < 7 && v >= 2) ? 2 : 1;
        access(0, s, 0, 16'h1000 + 16'(s*4+v), -1, exp_cyc,
               s == 7 ? "R6" : (v >= 2 ? "R4 R5" : "R3 R5"));
        access(0, s, 1, 16'h2000 + 16'(s*4+v), -1, exp_cyc,
               s == 7 ? "R6" : (v >= 2 ? "R4" : "R3"));
        idle(1);
      end

    // R7: wait pin ignored while disabled
    access(1, 0, 1, 16'h0020, -1, 1, "R2");
    access(0, 2, 0, 16'h0, 3, 2, "R7");
    access(0, 1, 1, 16'h0, 3, 1, "R7");

    // R8: wait pin stretch of 0..3 extra cycles
    access(1, 0, 1, 16'h4030, -1, 1, "R2");
    for (int k = 0; k < 4; k++) begin
      access(0, 2, 0, 16'h3000 + 16'(k), k, 2 + k, "R8");
      idle(1);
      access(0, 2, 1, 16'h3100 + 16'(k), k, 2 + k, "R8");
    end
    // R12: zero-wait slot with pin enabled and held
    access(0, 3, 0, 16'h0, 3, 1, "R12");
    access(0, 0, 0, 16'h0, 3, 1, "R12");
    // R6: internal slot with everything set
    access(1, 0, 1, 16'hFFFF, -1, 1, "R2");
    access(0, 7, 0, 16'h0, 3, 1, "R6");
    access(0, 6, 0, 16'h0, 2, 4, "R8");
    idle(2);
    chk(uo === 1'b1, "R11 bit15 set", uo, 1);
    access(1, 0, 1, 16'h0000, -1, 1, "R2");
    idle(1);
    chk(uo === 1'b0, "R11 bit15 clear", uo, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule